// File: doc/BRIEF.md
# ADC Acquisition Trigger Controller

This block decides in which clock cycles ADC samples are passed on to a downstream data port. A 32-bit control word, loaded with a one-cycle valid strobe, picks one of two acquisition modes. In continuous mode an external trigger acts as a level gate, and samples pass for as long as it sits at the chosen level. In burst mode a fixed number of samples is forwarded after a start event. The start event is either an edge of the chosen polarity on the external trigger, or, with the internal source selected, the arrival of the control word itself.

The same control word also selects where the ADC synchronization pulse comes from. It can be generated inside the block when a word arrives, or it can be relayed from an external input. The block keeps a sticky overrun flag that is raised when the downstream sample FIFO (511 entries of 16 bits, outside this block) reports full. Software clears the flag by draining the receiver and then writing a fresh control word. External trigger and sync pins are asynchronous and pass through a two-stage synchronizer before any use.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, capture_en, sync_out and overrun are low, and the configuration is continuous mode, trigger active high, external trigger source, external sync source.
- R2: In continuous mode (control bit 24 = 0), capture_en equals sample_valid AND (synchronized ext_trig equals control bit 26). Bit 26 = 1 means active high and 0 means active low. A change on ext_trig shows on capture_en two clock edges after the edge that samples it, and a new polarity takes effect from the edge that accepts the word.
- R3: In burst mode with external source (bit 24 = 1, bit 25 = 0), a rising edge (bit 26 = 1) or a falling edge (bit 26 = 0) of ext_trig starts a burst. capture_en can first rise three edges after the edge that samples the change. An edge of the other polarity starts nothing.
- R4: A burst forwards exactly BURST_LEN samples. Cycles with sample_valid low are not counted and show capture_en low.
- R5: Trigger edges that arrive while a burst is running are ignored and do not lengthen it. Edges of the wrong polarity after a burst start nothing.
- R6: A control word with bit 24 = 1 and bit 25 = 1 starts a burst whose first capture is possible in the cycle after the strobe. With this source selected, ext_trig has no effect.
- R7: With bit 23 = 1, each accepted control word yields a sync_out pulse exactly one cycle long, in the cycle after the strobe, and ext_sync is ignored.
- R8: With bit 23 = 0, sync_out follows ext_sync delayed by two clock edges.
- R9: overrun goes high at the edge that samples fifo_full high and stays high after fifo_full falls.
- R10: An accepted control word clears overrun at the same edge, unless fifo_full is high in that cycle, in which case overrun stays high.
- R11: A control word selecting continuous mode ends any running burst at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 32 | Control word (bit 23 sync source, 24 mode, 25 trigger source, 26 polarity) |
| ctrl_valid | input | 1 | One-cycle strobe that loads ctrl_word |
| ext_trig | input | 1 | Asynchronous external trigger |
| ext_sync | input | 1 | Asynchronous external sync pulse, active high |
| sample_valid | input | 1 | An ADC sample is available this cycle |
| fifo_full | input | 1 | Downstream sample FIFO is full |
| capture_en | output | 1 | Forward the current sample |
| sync_out | output | 1 | ADC synchronization pulse, active high |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Each result has a fixed delay from its stimulus. A control word changes capture gating, the internal sync pulse and overrun clearing one edge after its strobe. An ext_trig level reaches capture_en after two edges, and an ext_trig edge opens a burst after three. ext_sync reaches sync_out after two edges, and fifo_full reaches overrun after one. The driver records every expected output value together with the exact cycle number it is due in, and the monitor compares each entry only in that cycle, sampling after the inputs have settled. Burst ends are predicted by counting valid samples, including a gap in sample_valid and edges that arrive during the burst.

// File: rtl/atc_pkg.sv
package atc_pkg;

    typedef struct packed {
        logic burst;     // 1: burst mode, 0: continuous
        logic int_src;   // 1: control word starts bursts
        logic pol_high;  // level / edge polarity
        logic int_sync;  // 1: sync pulse made internally
    } atc_cfg_t;

    localparam atc_cfg_t CFG_RESET = '{burst: 1'b0, int_src: 1'b0,
                                       pol_high: 1'b1, int_sync: 1'b0};

endpackage

// File: rtl/atc_sync2.sv
module atc_sync2 #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/atc_cfg.sv
module atc_cfg
    import atc_pkg::*;
#(
    parameter int CW_W      = 32,
    parameter int POL_BIT   = 26,
    parameter int SRC_BIT   = 25,
    parameter int MODE_BIT  = 24,
    parameter int ISYNC_BIT = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW_W-1:0] ctrl_word,
    input  logic            ctrl_valid,
    output atc_cfg_t        word_cfg,
    output atc_cfg_t        cfg_q
);
    atc_cfg_t cfg_d;

    always_comb begin
        word_cfg.burst    = ctrl_word[MODE_BIT];
        word_cfg.int_src  = ctrl_word[SRC_BIT];
        word_cfg.pol_high = ctrl_word[POL_BIT];
        word_cfg.int_sync = ctrl_word[ISYNC_BIT];
        cfg_d = ctrl_valid ? word_cfg : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/atc_trigger.sv
module atc_trigger
    import atc_pkg::*;
#(
    parameter int BURST_LEN = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  atc_cfg_t cfg_q,
    input  atc_cfg_t word_cfg,
    input  logic     ctrl_valid,
    input  logic     trig_s,
    input  logic     sample_valid,
    output logic     capture_en
);
    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             trig_prev;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic rise, fall, edge_hit, level_on, gate;

    always_comb begin
        st_d           = st_q;
        st_d.trig_prev = trig_s;

        rise     = trig_s & ~st_q.trig_prev;
        fall     = ~trig_s & st_q.trig_prev;
        edge_hit = cfg_q.pol_high ? rise : fall;
        level_on = (trig_s == cfg_q.pol_high);
        gate     = cfg_q.burst ? st_q.active : level_on;
        capture_en = gate & sample_valid;

        if (st_q.active && capture_en) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (ctrl_valid) begin
            if (!word_cfg.burst) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else if (word_cfg.int_src && !st_q.active) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
            end
        end else if (cfg_q.burst && !cfg_q.int_src && !st_q.active && edge_hit) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/atc_status.sv
module atc_status
    import atc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  atc_cfg_t cfg_q,
    input  atc_cfg_t word_cfg,
    input  logic     ctrl_valid,
    input  logic     sync_s,
    input  logic     fifo_full,
    output logic     sync_out,
    output logic     overrun
);
    typedef struct packed {
        logic sync_pulse;
        logic overrun;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d.sync_pulse = ctrl_valid & word_cfg.int_sync;
        if (fifo_full)       st_d.overrun = 1'b1;
        else if (ctrl_valid) st_d.overrun = 1'b0;
        else                 st_d.overrun = st_q.overrun;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = cfg_q.int_sync ? st_q.sync_pulse : sync_s;
    assign overrun  = st_q.overrun;
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import atc_pkg::*;
#(
    parameter int CW_W        = 32,
    parameter int POL_BIT     = 26,
    parameter int SRC_BIT     = 25,
    parameter int MODE_BIT    = 24,
    parameter int ISYNC_BIT   = 23,
    parameter int BURST_LEN   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW_W-1:0] ctrl_word,
    input  logic            ctrl_valid,
    input  logic            ext_trig,
    input  logic            ext_sync,
    input  logic            sample_valid,
    input  logic            fifo_full,
    output logic            capture_en,
    output logic            sync_out,
    output logic            overrun
);
    atc_cfg_t   word_cfg, cfg_q;
    logic [1:0] pins_s;

    atc_sync2 #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din ({ext_sync, ext_trig}),
        .dout (pins_s)
    );

    atc_cfg #(
        .CW_W (CW_W), .POL_BIT (POL_BIT), .SRC_BIT (SRC_BIT),
        .MODE_BIT (MODE_BIT), .ISYNC_BIT (ISYNC_BIT)
    ) u_cfg (
        .clk (clk), .rst_n (rst_n),
        .ctrl_word (ctrl_word), .ctrl_valid (ctrl_valid),
        .word_cfg (word_cfg), .cfg_q (cfg_q)
    );

    atc_trigger #(.BURST_LEN(BURST_LEN)) u_trig (
        .clk (clk), .rst_n (rst_n),
        .cfg_q (cfg_q), .word_cfg (word_cfg), .ctrl_valid (ctrl_valid),
        .trig_s (pins_s[0]), .sample_valid (sample_valid),
        .capture_en (capture_en)
    );

    atc_status u_stat (
        .clk (clk), .rst_n (rst_n),
        .cfg_q (cfg_q), .word_cfg (word_cfg), .ctrl_valid (ctrl_valid),
        .sync_s (pins_s[1]), .fifo_full (fifo_full),
        .sync_out (sync_out), .overrun (overrun)
    );
endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
    parameter int CW_W      = 32,
    parameter int ISYNC_BIT = 23
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CW_W-1:0] ctrl_word,
    input logic            ctrl_valid,
    input logic            sample_valid,
    input logic            fifo_full,
    input logic            capture_en,
    input logic            sync_out,
    input logic            overrun
);
    logic isync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          isync_q <= 1'b0;
        else if (ctrl_valid) isync_q <= ctrl_word[ISYNC_BIT];
    end

    p_capture_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |-> sample_valid);

    p_sync_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ctrl_valid) && $past(ctrl_word[ISYNC_BIT]) |-> sync_out);

    p_sync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isync_q && !$past(ctrl_valid) |-> !sync_out);

    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fifo_full) |-> overrun);

    p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(overrun) && !$past(ctrl_valid) |-> overrun);

    p_overrun_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ctrl_valid) && !$past(fifo_full) |-> !overrun);
endmodule

bind adc_trig_ctrl atc_checker #(.CW_W(CW_W), .ISYNC_BIT(ISYNC_BIT)) u_chk (
    .clk (clk), .rst_n (rst_n), .ctrl_word (ctrl_word), .ctrl_valid (ctrl_valid),
    .sample_valid (sample_valid), .fifo_full (fifo_full),
    .capture_en (capture_en), .sync_out (sync_out), .overrun (overrun)
);

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;
    localparam int BL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        ctrl_valid = 1'b0, ext_trig = 1'b0, ext_sync = 1'b0;
    logic        sample_valid = 1'b1, fifo_full = 1'b0;
    logic        capture_en, sync_out, overrun;

    int cyc = 0, total = 0, bad = 0;
    bit done = 1'b0;

    typedef struct { int cyc; int fld; bit val; string req; } exp_t;
    exp_t sb[$];

    adc_trig_ctrl #(.BURST_LEN(BL)) dut (
        .clk (clk), .rst_n (rst_n), .ctrl_word (ctrl_word), .ctrl_valid (ctrl_valid),
        .ext_trig (ext_trig), .ext_sync (ext_sync), .sample_valid (sample_valid),
        .fifo_full (fifo_full), .capture_en (capture_en), .sync_out (sync_out),
        .overrun (overrun)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(bit burst, bit isrc, bit pol, bit isync);
        logic [31:0] w = '0;
        w[24] = burst; w[25] = isrc; w[26] = pol; w[23] = isync;
        return w;
    endfunction

    task automatic want(int c, int f, bit v, string r);
        exp_t e;
        e.cyc = c; e.fld = f; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    task automatic chk(bit act, bit exp, string r, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", r, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(logic [31:0] w);
        ctrl_word = w; ctrl_valid = 1'b1;
        tick(1);
        ctrl_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: pops due scoreboard entries once inputs have settled
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    bit a;
                    a = (sb[i].fld == 0) ? capture_en : (sb[i].fld == 1) ? sync_out : overrun;
                    chk(a, sb[i].val, sb[i].req,
                        (sb[i].fld == 0) ? "capture_en" : (sb[i].fld == 1) ? "sync_out" : "overrun");
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int e, w;
        tick(3);
        #3;
        chk(capture_en, 1'b0, "R1", "capture_en in reset");
        chk(sync_out,   1'b0, "R1", "sync_out in reset");
        chk(overrun,    1'b0, "R1", "overrun in reset");
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        e = cyc;
        want(e, 0, 0, "R1"); want(e, 1, 0, "R1"); want(e, 2, 0, "R1");

        // R2: continuous, active high by reset default
        tick(1); e = cyc; ext_trig = 1'b1;
        want(e + 1, 0, 0, "R2"); want(e + 2, 0, 1, "R2");
        tick(3);
        sample_valid = 1'b0; want(cyc, 0, 0, "R2");
        tick(1); sample_valid = 1'b1; tick(1);
        // R2: active low; trigger still high
        send(mk(0, 0, 0, 0)); want(cyc, 0, 0, "R2");
        e = cyc; ext_trig = 1'b0;
        want(e + 1, 0, 0, "R2"); want(e + 2, 0, 1, "R2");
        tick(3);

        // R7: internal sync pulse
        w = cyc; want(w, 1, 0, "R7");
        send(mk(0, 0, 0, 1));
        want(w + 1, 1, 1, "R7"); want(w + 2, 1, 0, "R7"); want(w + 3, 1, 0, "R7");
        tick(3);
        e = cyc; ext_sync = 1'b1; want(e + 2, 1, 0, "R7"); want(e + 3, 1, 0, "R7");
        tick(4); ext_sync = 1'b0; tick(3);

        // R8: external sync relay
        send(mk(0, 0, 1, 0)); tick(2);
        e = cyc; ext_sync = 1'b1;
        want(e + 1, 1, 0, "R8"); want(e + 2, 1, 1, "R8"); want(e + 3, 1, 0, "R8");
        tick(1); ext_sync = 1'b0; tick(4);

        // R3/R4/R5: burst on rising edge
        send(mk(1, 0, 1, 0)); tick(3);
        want(cyc, 0, 0, "R3");
        e = cyc; ext_trig = 1'b1;
        want(e + 2, 0, 0, "R3"); want(e + 3, 0, 1, "R3");
        for (int c = 10; c <= 14; c++) want(e + c, 0, 0, "R4");
        want(e + BL + 7, 0, 1, "R4"); want(e + BL + 8, 0, 0, "R4");
        want(e + BL + 9, 0, 0, "R5");
        for (int k = 0; k < BL + 12; k++) begin
            int c;
            c = cyc - e;
            sample_valid = !(c >= 10 && c <= 14);
            if (c == 12) ext_trig = 1'b0;
            if (c == 15) ext_trig = 1'b1;
            tick(1);
        end
        sample_valid = 1'b1;
        e = cyc; ext_trig = 1'b0;
        want(e + 3, 0, 0, "R5"); want(e + 4, 0, 0, "R5");
        tick(6);

        // R3: burst on falling edge
        send(mk(1, 0, 0, 0)); tick(2);
        e = cyc; ext_trig = 1'b1; want(e + 3, 0, 0, "R3"); want(e + 4, 0, 0, "R3");
        tick(5);
        e = cyc; ext_trig = 1'b0; want(e + 2, 0, 0, "R3"); want(e + 3, 0, 1, "R3");
        tick(6);

        // R11: continuous word aborts the running burst
        w = cyc;
        send(mk(0, 0, 1, 0));
        want(w + 1, 0, 0, "R11"); want(w + 4, 0, 0, "R11");
        tick(4); tick(2);

        // R6: internal burst, external trigger ignored
        w = cyc;
        send(mk(1, 1, 1, 0));
        want(w + 1, 0, 1, "R6"); want(w + BL, 0, 1, "R6");
        want(w + BL + 1, 0, 0, "R6"); want(w + BL + 6, 0, 0, "R6");
        ext_trig = 1'b1; tick(3); ext_trig = 1'b0; tick(BL + 4);
        ext_trig = 1'b1; tick(3);

        // R9/R10: overrun
        send(mk(0, 0, 0, 0)); tick(2);
        e = cyc; fifo_full = 1'b1;
        want(e + 1, 2, 1, "R9"); want(e + 6, 2, 1, "R9");
        tick(1); fifo_full = 1'b0; tick(7);
        w = cyc; send(mk(0, 0, 0, 0));
        want(w + 1, 2, 0, "R10");
        tick(2);
        e = cyc; fifo_full = 1'b1; tick(1);
        w = cyc; send(mk(0, 0, 0, 0));
        want(w + 1, 2, 1, "R10");
        fifo_full = 1'b0; tick(3);
        w = cyc; send(mk(0, 0, 0, 0));
        want(w + 1, 2, 0, "R10");
        tick(5);

        foreach (sb[i]) begin
            total++; bad++;
            $display("FAIL %s unchecked entry actual=none expected=cycle %0d", sb[i].req, sb[i].cyc);
        end
        finish_run();
    end
endmodule